// File: doc/BRIEF.md
# Three-Wire Register Access Slave

This block lets an external host read and write a small byte-wide register file over three wires: a serial clock, an active-low select and one shared data line. The block runs on its own system clock. It brings the serial clock, the select and the data line into that domain through synchronisers and finds their edges there. A transfer opens with a 16-bit command word. Its top bit picks read (1) or write (0). The next two bits code the byte count. The low 13 bits give the first register address. Whole data bytes follow the command. On a read the block takes over the data line for the data phase through a separate output-enable, and a pad tristate is built from that enable.

The command is laid out as direction in bit 15, the length code in bits 14:13 and the address in bits 12:0. Length code 00 moves one byte, 01 moves two, 10 moves three, and 11 keeps moving bytes until the select rises. The host may raise the select at a byte boundary to pause a counted transfer, and the transfer carries on when the select drops again. Bit 0 of the register at address 0 switches every later command and data byte to least-significant-bit-first order. In that order the address steps up after each byte. In the default order it steps down.

If the select input is high while power-on reset is applied, the serial port starts out disabled. The clock pin level then drives the output-format control and the data pin level drives the duty-cycle stabiliser control. The first low level seen on the select ends this pin-strap mode until the next reset. From then on both controls come from bits 0 and 1 of the register at address 1.

Top module: `ser_reg_slave`

## Requirements
- R1: When reset is released with select low, sdio_oe is 0, every register reads 0x00, and fmt_ctl_o and dcs_ctl_o are 0 and do not follow the clock or data pins.
- R2: A write command (bit 15 = 0) stores a data byte into the register file only after all 8 bits of that byte have been sampled on rising serial-clock edges.
- R3: For a read command (bit 15 = 1), sdio_oe stays 0 through the 16 command bits. It is 1 during the data bytes while select is low, and the register contents appear on sdio_o in the active bit order.
- R4: Length codes 00, 01 and 10 move exactly 1, 2 and 3 bytes. Any further bytes in the same select-low period are neither written nor driven.
- R5: After each data byte the address steps down by one in most-significant-first order and up by one in least-significant-first order, wrapping modulo 2^13.
- R6: Bit 0 of the register at address 0 selects least-significant-first order for both command and data bytes. Its reset value of 0 means most-significant-first.
- R7: Length code 11 keeps transferring bytes, each to or from the next address, until select rises. That rise ends the transfer.
- R8: In a counted transfer, select rising at a byte boundary pauses the transfer. sdio_oe is 0 while the select is high, and the transfer resumes at the same byte position when select falls.
- R9: Select rising with a byte partly shifted in drops that partial byte and abandons the transfer. The next select-low period starts with a fresh command.
- R10: With select high at reset, the port is disabled: sdio_oe is 0, fmt_ctl_o follows the clock pin level and dcs_ctl_o follows the data pin level.
- R11: The first low select level after a strap-mode reset enables the port for good, up to the next reset. fmt_ctl_o and dcs_ctl_o then equal bits 0 and 1 of the register at address 1.
- R12: Addresses at or above the register count read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select from the host |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven toward the pad during reads |
| sdio_oe | output | 1 | Pad output enable for the data line |
| fmt_ctl_o | output | 1 | Output-format control |
| dcs_ctl_o | output | 1 | Duty-cycle stabiliser enable control |

## Verification
Directed transfers come first. They cover a single-byte write followed by a read-back, and a three-byte write with a fourth, surplus byte. They also cover a streamed read across four registers, a pause inside the command and between data bytes, a transfer cut off after four data bits, an out-of-range address, and a switch to least-significant-first order and back. Each one checks for a different fault: a wrong length count, a wrong address direction, a lost position after a pause, or a partial byte that gets committed. After these, random reads and writes with random lengths, addresses and pauses run against a register model kept in the bench, and a full streamed read-back at the end exposes stray writes. A second reset with select held high tests the pin-strap controls and the one-way exit from that mode.

// File: rtl/ser_reg_pkg.sv
`timescale 1ns/1ps
package ser_reg_pkg;

    localparam int ADDR_W   = 13;
    localparam int BYTE_W   = 8;
    localparam int CMD_W    = 16;
    localparam int BCNT_W   = $clog2(BYTE_W);

    // fixed register roles
    localparam int CFG_ADDR     = 0;
    localparam int CFG_LSB_BIT  = 0;
    localparam int CTL_ADDR     = 1;
    localparam int CTL_FMT_BIT  = 0;
    localparam int CTL_DCS_BIT  = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CMD_W-1:0]  cmd_word_t;
    typedef logic [BCNT_W-1:0] bcnt_t;

    typedef enum logic [1:0] {
        LEN_ONE    = 2'b00,
        LEN_TWO    = 2'b01,
        LEN_THREE  = 2'b10,
        LEN_STREAM = 2'b11
    } len_e;

    typedef struct packed {
        logic  rd;
        len_e  len;
        addr_t addr;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_CMD  = 2'b00,
        PH_DATA = 2'b01,
        PH_DONE = 2'b10
    } phase_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    function automatic cmd_word_t cmd_shift(cmd_word_t s, logic b, logic lsb);
        return lsb ? {b, s[CMD_W-1:1]} : {s[CMD_W-2:0], b};
    endfunction

    function automatic byte_t byte_shift(byte_t s, logic b, logic lsb);
        return lsb ? {b, s[BYTE_W-1:1]} : {s[BYTE_W-2:0], b};
    endfunction

    function automatic logic bit_pick(byte_t d, bcnt_t idx, logic lsb);
        return lsb ? d[idx] : d[bcnt_t'(BYTE_W-1) - idx];
    endfunction

    function automatic addr_t addr_step(addr_t a, logic lsb);
        return lsb ? a + addr_t'(1) : a - addr_t'(1);
    endfunction

endpackage

// File: rtl/ser_sync.sv
`timescale 1ns/1ps
module ser_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= {STAGES{RST_VAL}};
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/ser_regfile.sv
`timescale 1ns/1ps
module ser_regfile
    import ser_reg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr_i,
    input  addr_t   rd_addr_i,
    output byte_t   rd_data_o,
    output logic    cfg_lsb_o,
    output logic    ctl_fmt_o,
    output logic    ctl_dcs_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_i.en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_i.addr == addr_t'(i)) begin
                    regs_q[i] <= wr_i.data;
                end
            end
        end
    end

    always_comb begin
        if (rd_addr_i < addr_t'(NUM_REGS)) begin
            rd_data_o = regs_q[rd_addr_i[IDX_W-1:0]];
        end else begin
            rd_data_o = '0;
        end
    end

    assign cfg_lsb_o = regs_q[CFG_ADDR][CFG_LSB_BIT];
    assign ctl_fmt_o = regs_q[CTL_ADDR][CTL_FMT_BIT];
    assign ctl_dcs_o = regs_q[CTL_ADDR][CTL_DCS_BIT];
endmodule

// File: rtl/ser_frame.sv
`timescale 1ns/1ps
module ser_frame
    import ser_reg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  logic    sclk_s,
    input  logic    csn_s,
    input  logic    sdio_s,
    input  logic    lsb_first_i,
    input  byte_t   rd_data_i,
    output addr_t   rd_addr_o,
    output wr_req_t wr_o,
    output logic    sdio_o,
    output logic    sdio_oe
);
    phase_e    phase_q;
    bcnt_t     bit_cnt_q;
    logic      cmd_hi_q;
    cmd_word_t cmd_sr_q;
    logic      rd_q;
    len_e      len_q;
    addr_t     addr_q;
    logic [1:0] byte_idx_q;
    byte_t     rx_sr_q;
    logic      sclk_q;
    logic      csn_q;
    wr_req_t   wr_q;

    logic  cs_rise;
    logic  clk_rise;
    logic  byte_end;
    cmd_t  cmd_next;
    byte_t rx_next;

    assign cs_rise  = csn_s && !csn_q;
    assign clk_rise = !csn_s && sclk_s && !sclk_q;
    assign byte_end = (bit_cnt_q == bcnt_t'(BYTE_W-1));
    assign cmd_next = cmd_t'(cmd_shift(cmd_sr_q, sdio_s, lsb_first_i));
    assign rx_next  = byte_shift(rx_sr_q, sdio_s, lsb_first_i);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            phase_q    <= PH_CMD;
            bit_cnt_q  <= '0;
            cmd_hi_q   <= 1'b0;
            cmd_sr_q   <= '0;
            rd_q       <= 1'b0;
            len_q      <= LEN_ONE;
            addr_q     <= '0;
            byte_idx_q <= '0;
            rx_sr_q    <= '0;
            sclk_q     <= 1'b0;
            csn_q      <= 1'b1;
            wr_q       <= '0;
        end else begin
            sclk_q  <= sclk_s;
            csn_q   <= csn_s;
            wr_q.en <= 1'b0;
            if (cs_rise) begin
                bit_cnt_q <= '0;
                if ((bit_cnt_q != '0) || (phase_q == PH_DONE) ||
                    ((phase_q == PH_DATA) && (len_q == LEN_STREAM))) begin
                    phase_q  <= PH_CMD;
                    cmd_hi_q <= 1'b0;
                end
            end else if (clk_rise) begin
                case (phase_q)
                    PH_CMD: begin
                        bit_cnt_q <= bit_cnt_q + bcnt_t'(1);
                        cmd_sr_q  <= cmd_shift(cmd_sr_q, sdio_s, lsb_first_i);
                        if (byte_end) begin
                            if (cmd_hi_q) begin
                                cmd_hi_q   <= 1'b0;
                                rd_q       <= cmd_next.rd;
                                len_q      <= cmd_next.len;
                                addr_q     <= cmd_next.addr;
                                byte_idx_q <= '0;
                                phase_q    <= PH_DATA;
                            end else begin
                                cmd_hi_q <= 1'b1;
                            end
                        end
                    end
                    PH_DATA: begin
                        bit_cnt_q <= bit_cnt_q + bcnt_t'(1);
                        rx_sr_q   <= rx_next;
                        if (byte_end) begin
                            if (!rd_q) begin
                                wr_q.en   <= 1'b1;
                                wr_q.addr <= addr_q;
                                wr_q.data <= rx_next;
                            end
                            addr_q     <= addr_step(addr_q, lsb_first_i);
                            byte_idx_q <= byte_idx_q + 2'd1;
                            if ((len_q != LEN_STREAM) && (byte_idx_q == 2'(len_q))) begin
                                phase_q <= PH_DONE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr_o = addr_q;
    assign wr_o      = wr_q;
    assign sdio_oe   = (phase_q == PH_DATA) && rd_q && !csn_s;
    assign sdio_o    = bit_pick(rd_data_i, bit_cnt_q, lsb_first_i);
endmodule

// File: rtl/ser_reg_slave.sv
`timescale 1ns/1ps
module ser_reg_slave
    import ser_reg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic fmt_ctl_o,
    output logic dcs_ctl_o
);
    logic    sclk_s;
    logic    csn_s;
    logic    sdio_s;
    logic    strap_q;
    addr_t   rd_addr;
    byte_t   rd_data;
    wr_req_t wr_req;
    logic    cfg_lsb;
    logic    ctl_fmt;
    logic    ctl_dcs;

    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_s)
    );
    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst(rst), .d(csn_i), .q(csn_s)
    );
    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdio (
        .clk(clk), .rst(rst), .d(sdio_i), .q(sdio_s)
    );

    // strap captured from the raw pin during reset, cleared for good by a low select
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= csn_i;
        end else if (!csn_s) begin
            strap_q <= 1'b0;
        end
    end

    ser_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .en_i       (!strap_q),
        .sclk_s     (sclk_s),
        .csn_s      (csn_s),
        .sdio_s     (sdio_s),
        .lsb_first_i(cfg_lsb),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_o       (wr_req),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe)
    );

    ser_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_req),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .cfg_lsb_o(cfg_lsb),
        .ctl_fmt_o(ctl_fmt),
        .ctl_dcs_o(ctl_dcs)
    );

    assign fmt_ctl_o = strap_q ? sclk_s : ctl_fmt;
    assign dcs_ctl_o = strap_q ? sdio_s : ctl_dcs;
endmodule

// File: rtl/ser_reg_slave_chk.sv
`timescale 1ns/1ps
module ser_reg_slave_chk (
    input logic clk,
    input logic rst,
    input logic strap,
    input logic csn_s,
    input logic sdio_oe,
    input logic wr_en
);
    assert_port_off_in_strap_R10: assert property (@(posedge clk) disable iff (rst)
        strap |-> !sdio_oe);

    assert_strap_exit_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        !strap |=> !strap);

    assert_drive_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !csn_s);

    assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(csn_s) |=> !sdio_oe);

    assert_write_not_during_read_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!strap && !$past(sdio_oe)));
endmodule

bind ser_reg_slave ser_reg_slave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .strap  (strap_q),
    .csn_s  (csn_s),
    .sdio_oe(sdio_oe),
    .wr_en  (wr_req.en)
);

// File: tb/ser_reg_slave_tb.sv
`timescale 1ns/1ps
module ser_reg_slave_tb_top;
    localparam int NREG = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csn = 1'b0;
    logic host_bit = 1'b0;
    logic sdio_o, sdio_oe, fmt, dcs, line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mreg [NREG];
    logic [7:0] tx_buf [16];

    assign line = sdio_oe ? sdio_o : host_bit;

    always #2.5 clk = ~clk;

    ser_reg_slave #(.NUM_REGS(NREG)) dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .sdio_i(line),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .fmt_ctl_o(fmt), .dcs_ctl_o(dcs)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd(input logic [12:0] a);
        return (a < NREG) ? mreg[a] : 8'h00;
    endfunction

    function automatic bit m_lsb();
        return mreg[0][0];
    endfunction

    task automatic m_wr(input logic [12:0] a, input logic [7:0] d);
        if (a < NREG) mreg[a] = d;
    endtask

    task automatic xfer_bits(input logic [7:0] d, input bit lsb, input int nbits,
                             output logic [7:0] r, output bit oe_all, output bit oe_any);
        r = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            host_bit = d[idx];
            wait_clk(HALF);
            r[idx] = line;
            oe_all &= sdio_oe;
            oe_any |= sdio_oe;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic pause_cs();
        csn = 1'b1;
        wait_clk(6);
        check(sdio_oe == 1'b0, "R8 oe while paused", sdio_oe, 0);
        wait_clk(14);
        csn = 1'b0;
        wait_clk(4);
    endtask

    task automatic run_frame(input bit rw, input logic [1:0] len, input logic [12:0] addr,
                             input int n, input int stall_at, input bit stall_cmd,
                             input int cut_bits, input string tag);
        logic [15:0] cmd;
        logic [7:0] got, expv, b0, b1;
        logic [12:0] a;
        bit lsb, oe_all, oe_any, oe_cmd;
        int nb;
        cmd = {rw, len, addr};
        nb = (len == 2'b11) ? 1000 : int'(len) + 1;
        lsb = m_lsb();
        b0 = lsb ? cmd[7:0] : cmd[15:8];
        b1 = lsb ? cmd[15:8] : cmd[7:0];
        csn = 1'b0;
        wait_clk(4);
        xfer_bits(b0, lsb, 8, got, oe_all, oe_any);
        oe_cmd = oe_any;
        if (stall_cmd) pause_cs();
        xfer_bits(b1, lsb, 8, got, oe_all, oe_any);
        oe_cmd |= oe_any;
        check(!oe_cmd, "R3 oe during command", oe_cmd, 0);
        a = addr;
        for (int k = 0; k < n; k++) begin
            if (k == stall_at) pause_cs();
            lsb = m_lsb();
            xfer_bits(tx_buf[k], lsb, 8, got, oe_all, oe_any);
            if (k < nb) begin
                if (rw) begin
                    expv = m_rd(a);
                    check(got == expv, {tag, " read data"}, got, expv);
                    if (k == 0) check(oe_all, "R3 oe during data", oe_all, 1);
                end else begin
                    m_wr(a, tx_buf[k]);
                end
                a = lsb ? a + 13'd1 : a - 13'd1;
            end else begin
                check(!oe_any, "R4 oe after last byte", oe_any, 0);
            end
        end
        if (cut_bits > 0) xfer_bits(8'hFF, m_lsb(), cut_bits, got, oe_all, oe_any);
        wait_clk(4);
        csn = 1'b1;
        wait_clk(20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-to-end act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;

        // reset with select low: port enabled
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);
        csn = 1'b1;
        wait_clk(6);
        check(sdio_oe == 1'b0, "R1 oe after reset", sdio_oe, 0);
        check(fmt == 1'b0, "R1 fmt after reset", fmt, 0);
        check(dcs == 1'b0, "R1 dcs after reset", dcs, 0);
        sclk = 1'b1; host_bit = 1'b1;
        wait_clk(6);
        check(fmt == 1'b0 && dcs == 1'b0, "R1 controls ignore pins", {fmt, dcs}, 0);
        sclk = 1'b0; host_bit = 1'b0;
        wait_clk(6);
        run_frame(1, 2'b00, 13'd3, 1, -1, 0, 0, "R1");

        // single byte write then read
        tx_buf[0] = 8'hA5;
        run_frame(0, 2'b00, 13'd2, 1, -1, 0, 0, "R2");
        run_frame(1, 2'b00, 13'd2, 1, -1, 0, 0, "R2");
        check(mreg[2] == 8'hA5, "R2 model", mreg[2], 8'hA5);

        // three bytes plus a surplus byte, then streamed read
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'hFF;
        run_frame(0, 2'b10, 13'd5, 4, -1, 0, 0, "R4");
        for (int k = 0; k < 4; k++) tx_buf[k] = 8'h00;
        run_frame(1, 2'b11, 13'd5, 4, -1, 0, 0, "R5");
        run_frame(1, 2'b00, 13'd1, 1, -1, 0, 0, "R4");

        // partial byte dropped
        run_frame(0, 2'b00, 13'd6, 0, -1, 0, 4, "R9");
        run_frame(1, 2'b00, 13'd6, 1, -1, 0, 0, "R9");

        // pauses inside command and between bytes
        tx_buf[0] = 8'h5A; tx_buf[1] = 8'hC3;
        run_frame(0, 2'b01, 13'd7, 2, 1, 1, 0, "R8");
        run_frame(1, 2'b01, 13'd7, 2, 1, 0, 0, "R8");

        // out of range address
        tx_buf[0] = 8'h77;
        run_frame(0, 2'b00, 13'd9, 1, -1, 0, 0, "R12");
        run_frame(1, 2'b00, 13'd9, 1, -1, 0, 0, "R12");

        // streamed write with wrap below zero
        tx_buf[0] = 8'h40; tx_buf[1] = 8'h66; tx_buf[2] = 8'h00;
        run_frame(0, 2'b11, 13'd1, 3, -1, 0, 0, "R7");
        run_frame(1, 2'b11, 13'd1, 3, -1, 0, 0, "R7");

        // switch to lsb-first order and back
        tx_buf[0] = 8'h01;
        run_frame(0, 2'b00, 13'd0, 1, -1, 0, 0, "R6");
        tx_buf[0] = 8'h03; tx_buf[1] = 8'h5C;
        run_frame(0, 2'b01, 13'd1, 2, -1, 0, 0, "R6");
        check(fmt == 1'b1 && dcs == 1'b1, "R11 controls from register", {fmt, dcs}, 2'b11);
        run_frame(1, 2'b01, 13'd0, 2, -1, 0, 0, "R6");
        tx_buf[0] = 8'h00;
        run_frame(0, 2'b00, 13'd0, 1, -1, 0, 0, "R6");
        run_frame(1, 2'b10, 13'd2, 3, -1, 0, 0, "R6");

        // random traffic against the model
        for (int f = 0; f < 40; f++) begin
            bit rw;
            logic [1:0] len;
            logic [12:0] a;
            int nb, n, st;
            rw = 1'($urandom % 2);
            len = 2'($urandom % 4);
            a = 13'($urandom % 10);
            nb = (len == 2'b11) ? 0 : int'(len) + 1;
            n = (len == 2'b11) ? 1 + int'($urandom % 4) : nb + int'($urandom % 2);
            st = (len != 2'b11 && ($urandom % 3) == 0) ? int'($urandom % nb) : -1;
            for (int k = 0; k < n; k++) tx_buf[k] = 8'($urandom);
            run_frame(rw, len, a, n, st, 0, 0, rw ? "R3" : "R2");
        end

        // full read-back
        for (int k = 0; k < 16; k++) tx_buf[k] = 8'h00;
        if (m_lsb()) run_frame(1, 2'b11, 13'd0, NREG, -1, 0, 0, "R7");
        else         run_frame(1, 2'b11, 13'(NREG - 1), NREG, -1, 0, 0, "R7");
        check(fmt == mreg[1][0] && dcs == mreg[1][1], "R11 controls follow register",
              {fmt, dcs}, {mreg[1][0], mreg[1][1]});

        // strap mode: select high at reset
        sclk = 1'b0; host_bit = 1'b0; csn = 1'b1;
        rst = 1'b1;
        wait_clk(6);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        wait_clk(4);
        sclk = 1'b1; host_bit = 1'b0;
        wait_clk(6);
        check(fmt == 1'b1 && dcs == 1'b0, "R10 strap pins 10", {fmt, dcs}, 2'b10);
        check(sdio_oe == 1'b0, "R10 oe in strap", sdio_oe, 0);
        sclk = 1'b0; host_bit = 1'b1;
        wait_clk(6);
        check(fmt == 1'b0 && dcs == 1'b1, "R10 strap pins 01", {fmt, dcs}, 2'b01);
        csn = 1'b0;
        wait_clk(6);
        csn = 1'b1;
        wait_clk(4);
        sclk = 1'b1; host_bit = 1'b1;
        wait_clk(6);
        check(fmt == 1'b0 && dcs == 1'b0, "R11 strap left", {fmt, dcs}, 0);
        sclk = 1'b0; host_bit = 1'b0;
        wait_clk(6);
        tx_buf[0] = 8'h02;
        run_frame(0, 2'b00, 13'd1, 1, -1, 0, 0, "R11");
        check(fmt == 1'b0 && dcs == 1'b1, "R11 port active after strap", {fmt, dcs}, 2'b01);
        run_frame(1, 2'b00, 13'd1, 1, -1, 0, 0, "R11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule